// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between a PWM generator and the two gate drivers of a synchronous buck stage. It turns one PWM request into separate high-side and low-side gate commands that never overlap. It does not insert a fixed delay between them. It waits for sensed evidence that one switch is off before it turns on the other. Two comparator flags supply that evidence. One shows that the switch node has fallen low. The other shows that the low-side gate voltage has fallen low.

When the inductor current is negative, the switch node does not fall after the high side turns off. In that case a watchdog turns the low side on anyway, so the current can recirculate.

Two control inputs adjust the sequence:
- A low-side enable masks the low switch during startup over a pre-biased output. While it is low, the low side stays off and the switch-node wait is skipped.
- An overvoltage force input overrides the sequence. It turns the high side off and the low side on.

Each high-side pulse is limited to a fixed fraction of the switching period.

Top module: `dt_gate_seq`

## Requirements
- R1: During and after reset, both gate commands are low. The sequencer stays idle, and no high-side pulse starts until a PWM request arrives.
- R2: `hs_gate` and `ls_gate` are never high in the same clock cycle.
- R3: When a PWM request arrives, `hs_gate` rises only after a clock edge at which `lsg_low` was sampled high while the low side was off. It rises one cycle after that edge. While `lsg_low` stays low, `hs_gate` stays low.
- R4: When the request falls, `hs_gate` drops on the next cycle. `ls_gate` then rises one cycle after the first edge that samples `phase_low` high.
- R5: If `phase_low` never asserts after the high side turns off, `ls_gate` rises after exactly `WDOG_CYC` cycles with both gates low (default 8).
- R6: While `ls_en` is low and `ov_force` is low, `ls_gate` stays low. After high-side turn-off the switch-node wait is skipped, so a new request can start the high side two cycles after the previous one ended.
- R7: While `ov_force` is high, the next cycle shows `hs_gate` low and `ls_gate` high, regardless of `pwm_req` and `ls_en`. On release with `pwm_req` high, the sequencer passes through a low-side-off wait before the high side turns on again.
- R8: A high-side pulse lasts at most `MAX_ON = PERIOD_CYC*DUTY_PCT/100` cycles (default 16). A truncated request starts no new pulse until `pwm_req` has been low for at least one cycle.
- R9: A request that rises while the switch-node wait is in progress is honored only after that wait completes. `ls_gate` goes high for exactly one cycle. Then both gates are low for one cycle, and then `hs_gate` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | PWM request; high asks for the high side on |
| phase_low | input | 1 | Comparator flag: switch node has fallen low |
| lsg_low | input | 1 | Comparator flag: low-side gate voltage is low |
| ls_en | input | 1 | Low-side enable; low masks the low switch |
| ov_force | input | 1 | Overvoltage override: high side off, low side on |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
The request is driven with each comparator flag held back and then released. Holding `lsg_low` low separates adaptive waiting from a fixed delay. Releasing `phase_low` in mid-wait separates the sensed path from the watchdog path, and withholding it entirely measures the watchdog length. Further runs cover the masked low side, the override at different states, a request held past the on-time limit, and a request that returns during the switch-node wait. Each of these tells apart the branch taken from its neighbours by the exact cycle at which each gate changes.

// File: rtl/dt_gate_seq.sv
module dt_gate_seq #(
  parameter int PERIOD_CYC = 20,
  parameter int DUTY_PCT   = 80,
  parameter int WDOG_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic phase_low,
  input  logic lsg_low,
  input  logic ls_en,
  input  logic ov_force,
  output logic hs_gate,
  output logic ls_gate
);

  localparam int MAX_ON = PERIOD_CYC * DUTY_PCT / 100;
  localparam int OW = $clog2(MAX_ON + 1);
  localparam int WW = $clog2(WDOG_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HS, S_WPH, S_LS, S_WLG, S_OVR
  } st_t;

  st_t st, nxt;
  logic [OW-1:0] on_cnt;
  logic [WW-1:0] wd_cnt;
  logic need_fall;

  wire on_last = (on_cnt == OW'(MAX_ON - 1));
  wire wd_last = (wd_cnt == WW'(WDOG_CYC - 1));
  wire req_ok  = pwm_req && !need_fall;

  always_comb begin
    nxt = st;
    if (ov_force) nxt = S_OVR;
    else begin
      case (st)
        S_IDLE: if (req_ok && lsg_low) nxt = S_HS;
        S_HS:   if (!pwm_req || on_last) nxt = ls_en ? S_WPH : S_IDLE;
        S_WPH: begin
          if (!ls_en) nxt = S_IDLE;
          else if (phase_low || wd_last) nxt = S_LS;
        end
        S_LS:   if (!ls_en || req_ok) nxt = S_WLG;
        S_WLG:  if (lsg_low) nxt = req_ok ? S_HS : S_IDLE;
        S_OVR:  nxt = (ls_en && !pwm_req) ? S_LS : S_WLG;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      on_cnt    <= '0;
      wd_cnt    <= '0;
      need_fall <= 1'b0;
    end else begin
      st     <= nxt;
      on_cnt <= (st == S_HS && nxt == S_HS) ? on_cnt + 1'b1 : '0;
      wd_cnt <= (st == S_WPH && nxt == S_WPH) ? wd_cnt + 1'b1 : '0;
      if (!pwm_req) need_fall <= 1'b0;
      else if (st == S_HS && on_last) need_fall <= 1'b1;
    end
  end

  assign hs_gate = (st == S_HS);
  assign ls_gate = (st == S_LS) || (st == S_OVR);

endmodule

// File: rtl/dt_gate_seq_chk.sv
module dt_gate_seq_chk #(
  parameter int MAX_ON = 16
) (
  input logic clk,
  input logic rst_n,
  input logic lsg_low,
  input logic ls_en,
  input logic ov_force,
  input logic hs_gate,
  input logic ls_gate
);

  localparam int RW = $clog2(MAX_ON + 2);
  logic [RW-1:0] hs_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_run <= '0;
    else if (hs_gate) hs_run <= hs_run + 1'b1;
    else hs_run <= '0;
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r4_ls_waits: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) && !$past(ov_force) |-> !ls_gate);

  a_r3_hs_after_lsg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(lsg_low) && !$past(ls_gate));

  a_r6_ls_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(ls_en) || $past(ov_force));

  a_r7_ov_override: assert property (@(posedge clk) disable iff (!rst_n)
    ov_force |=> ls_gate && !hs_gate);

  a_r8_max_on: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> hs_run < RW'(MAX_ON));

endmodule

bind dt_gate_seq dt_gate_seq_chk #(.MAX_ON(PERIOD_CYC * DUTY_PCT / 100)) u_chk (
  .clk(clk), .rst_n(rst_n), .lsg_low(lsg_low), .ls_en(ls_en),
  .ov_force(ov_force), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/dt_gate_seq_tb.sv
`timescale 1ns/1ps
module dt_gate_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_req, phase_low, lsg_low, ls_en, ov_force;
  logic hs_gate, ls_gate;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dt_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .phase_low(phase_low),
    .lsg_low(lsg_low), .ls_en(ls_en), .ov_force(ov_force),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 overlap", hs_gate && ls_gate, 1'b0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pwm_req = 0; phase_low = 0; lsg_low = 1; ls_en = 1; ov_force = 0;
    tick(2);
    chk("R1 hs in reset", hs_gate, 1'b0);
    chk("R1 ls in reset", ls_gate, 1'b0);
    rst_n = 1;
    tick(1);
  endtask

  task automatic t_reset_idle();
    do_reset();
    tick(5);
    chk("R1 hs idle", hs_gate, 1'b0);
    chk("R1 ls idle", ls_gate, 1'b0);
  endtask

  task automatic t_hs_wait();
    do_reset();
    lsg_low = 0; pwm_req = 1;
    tick(3);
    chk("R3 hs held off", hs_gate, 1'b0);
    lsg_low = 1;
    tick(1);
    chk("R3 hs on", hs_gate, 1'b1);
    chk("R3 ls off", ls_gate, 1'b0);
  endtask

  task automatic t_phase();
    do_reset();
    pwm_req = 1; tick(3);
    pwm_req = 0; tick(1);
    chk("R4 hs off", hs_gate, 1'b0);
    chk("R4 ls waits", ls_gate, 1'b0);
    tick(2);
    chk("R4 ls still waits", ls_gate, 1'b0);
    phase_low = 1; tick(1);
    chk("R4 ls on", ls_gate, 1'b1);
  endtask

  task automatic t_watchdog();
    do_reset();
    pwm_req = 1; tick(3);
    pwm_req = 0; tick(8);
    chk("R5 before timeout", ls_gate, 1'b0);
    tick(1);
    chk("R5 timeout ls on", ls_gate, 1'b1);
  endtask

  task automatic t_mask();
    do_reset();
    ls_en = 0; phase_low = 1;
    pwm_req = 1; tick(3);
    pwm_req = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      chk("R6 ls masked", ls_gate, 1'b0);
    end
    pwm_req = 1; tick(2);
    pwm_req = 0; tick(1);
    chk("R6 hs off", hs_gate, 1'b0);
    pwm_req = 1; tick(1);
    chk("R6 wait skipped hs on", hs_gate, 1'b1);
  endtask

  task automatic t_ovr();
    do_reset();
    pwm_req = 1; tick(3);
    ov_force = 1; tick(1);
    chk("R7 hs forced off", hs_gate, 1'b0);
    chk("R7 ls forced on", ls_gate, 1'b1);
    ls_en = 0; tick(4);
    chk("R7 hold hs", hs_gate, 1'b0);
    chk("R7 hold ls over mask", ls_gate, 1'b1);
    ls_en = 1; ov_force = 0; tick(1);
    chk("R7 release ls off", ls_gate, 1'b0);
    chk("R7 release hs waits", hs_gate, 1'b0);
    tick(1);
    chk("R7 resume hs", hs_gate, 1'b1);
  endtask

  task automatic t_trunc();
    int hs_cnt = 0;
    do_reset();
    phase_low = 1; pwm_req = 1;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (hs_gate) hs_cnt++;
    end
    chk("R8 on-time is 16", hs_cnt == 16, 1'b1);
    chk("R8 ls on after truncation", ls_gate, 1'b1);
    pwm_req = 0; tick(1);
    pwm_req = 1; tick(1);
    chk("R8 ls off for new pulse", ls_gate, 1'b0);
    tick(1);
    chk("R8 new pulse", hs_gate, 1'b1);
  endtask

  task automatic t_toggle();
    do_reset();
    pwm_req = 1; tick(3);
    pwm_req = 0; tick(1);
    pwm_req = 1; phase_low = 1; tick(1);
    chk("R9 ls on first", ls_gate, 1'b1);
    chk("R9 hs held", hs_gate, 1'b0);
    tick(1);
    chk("R9 ls off", ls_gate, 1'b0);
    chk("R9 hs not yet", hs_gate, 1'b0);
    tick(1);
    chk("R9 hs on", hs_gate, 1'b1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_idle();
    t_hs_wait();
    t_phase();
    t_watchdog();
    t_mask();
    t_ovr();
    t_trunc();
    t_toggle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule